// File: doc/BRIEF.md
# Compare-Driven Timer Channel

This block is one 16-bit up-counting timer channel with a small register port. Its count clock comes from one of several sources: four prescaled versions of the system clock, a slow clock input, or a chained input from another channel. Both external inputs are synchronised and edge-detected inside the block. Each selected tick advances the counter while the channel clock is enabled.

Software chooses the operating mode. In free mode the counter wraps past its maximum. In auto-reload mode it returns to zero when it matches RC. A stop bit turns auto-reload into a one-shot timer, which halts the channel clock on the RC match. Two compare values shape an output line: it rises on an RA match and falls on an RC match. This gives a duty-cycled waveform that can clock a second channel.

Compare and overflow events are latched as status flags, and reading the status register clears them. Write-one-to-set and write-one-to-clear registers edit an interrupt mask. The interrupt line is the OR of the flags that are enabled in that mask.

Top module: `tmr_chan`

## Requirements
- R1: In free mode (MODE bit 3 = 0), the counter increments on each tick. From 0xFFFF it wraps to 0 and sets status bit 0 (overflow). An RC match does not reset it.
- R2: In auto-reload mode (MODE bit 3 = 1), a tick that finds the counter equal to RC loads zero instead of incrementing. The count therefore cycles through 0..RC.
- R3: When MODE bit 4 (stop on RC) is set, an RC match sets status bit 2 and clears the channel clock enable. The counter then holds until a new enable command.
- R4: A command write (address 1) with bit 0 (enable) and bit 2 (trigger) starts the clock and clears the counter and prescaler. A trigger alone restarts the count from zero without changing the enable.
- R5: Command bit 1 (disable) stops counting and takes priority over bit 0 in the same write. Status bit 7 reads 1 exactly while the channel clock is enabled.
- R6: The output line goes high one cycle after a tick with count equal to RA. It goes low one cycle after a tick with count equal to RC, and RC wins when both match.
- R7: A write to address 4 sets the mask bits that are 1 in wdata[7:0]. A write to address 5 clears them, so writing 0xFF clears all eight. Address 6 reads the mask back.
- R8: irq is high whenever a latched status flag (bits 0 to 2) is set and its mask bit is set.
- R9: A read of status (address 7, rd_en high) returns the flags and clears bits 0 to 2 at the next edge. An event in that same cycle still sets its flag.
- R10: MODE bits [2:0] select the source. Codes 0 to 3 give one tick every 2, 8, 32 and 128 system clocks, counted from the last trigger.
- R11: Code 4 counts rising edges of slow_clk and code 5 counts rising edges of ext_clk, each after a two-stage synchroniser. Codes 6 and 7 give no ticks. An unselected input never advances the count.
- R12: Register map: 0 MODE (read/write), 1 command on write and current count on read, 2 RA, 3 RC, 4 mask set, 5 mask clear, 6 mask, 7 status. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow clock source (asynchronous) |
| ext_clk | input | 1 | Chained input from another channel (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 7) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Compare-shaped waveform output |

## Verification
The bench aims at the edges of the count. It checks the wrap from 0xFFFF, where a design that compared against RC in free mode would never reach the top. It checks the return to zero in auto-reload mode, where an off-by-one would cycle through RC+1 or RC-1 values. It checks the one-shot stop, where a design that kept running would leave the enable bit set and the count non-zero.

It also writes enable and disable together, which a design without the stated priority would leave running. It counts pulses on the unselected external input, which must not move the count. Finally, it reads status twice, because a missing clear-on-read keeps irq high after the handler has read the flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_CMD  = 3'd1,
    A_RA   = 3'd2,
    A_RC   = 3'd3,
    A_IEN  = 3'd4,
    A_IDIS = 3'd5,
    A_MASK = 3'd6,
    A_STAT = 3'd7
  } reg_addr_e;

  localparam logic [2:0] SRC_SLOW = 3'd4;
  localparam logic [2:0] SRC_EXT  = 3'd5;

  localparam int ST_OVF   = 0;
  localparam int ST_RA    = 1;
  localparam int ST_RC    = 2;
  localparam int ST_CLKON = 7;

  localparam int MODE_W    = 5;
  localparam int MODE_AUTO = 3;
  localparam int MODE_STOP = 4;

  // log2 of the prescale ratio for source codes 0..3
  function automatic int div_log2(input int code);
    return 1 + 2 * code;
  endfunction

  // next count on an advancing tick
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic reload_now);
    return reload_now ? 16'd0 : cur + 16'd1;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_N-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC_N-2:0], async_in};
      prev_q <= sh_q[SYNC_N-1];
    end
  end

  assign rise = sh_q[SYNC_N-1] & ~prev_q;

  // R11: a detected edge lasts exactly one cycle
  assert_single_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise) else $error("edge pulse longer than one cycle");

endmodule

// File: rtl/tmr_clksel.sv
module tmr_clksel
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       slow_in,
  input  logic       ext_in,
  output logic       tick
);
  localparam int N_DIV = 4;

  logic [PRE_W-1:0] pre_q;
  logic [N_DIV-1:0] div_tick;
  logic             slow_rise, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    localparam int LB = div_log2(g);
    assign div_tick[g] = &pre_q[LB-1:0];
  end

  tmr_edge_sync #(.SYNC_N(SYNC_N)) u_slow (
    .clk(clk), .rst_n(rst_n), .async_in(slow_in), .rise(slow_rise));
  tmr_edge_sync #(.SYNC_N(SYNC_N)) u_ext (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .rise(ext_rise));

  always_comb begin
    if (sel[2] == 1'b0)       tick = div_tick[sel[1:0]];
    else if (sel == SRC_SLOW) tick = slow_rise;
    else if (sel == SRC_EXT)  tick = ext_rise;
    else                      tick = 1'b0;
  end

  // R10: the divide-by-2 source never ticks on two cycles in a row
  assert_div2_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && tick && !restart) |=> !div_tick[0])
    else $error("divide-by-2 tick repeated");

  // R11: unused codes never tick
  assert_no_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2] && sel[1]) |-> !tick) else $error("tick on unused source");

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_rld,
  input  logic             stop_rc,
  input  logic [CNT_W-1:0] ra,
  input  logic [CNT_W-1:0] rc,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             cmd_trig,
  output logic [CNT_W-1:0] cnt,
  output logic             clken,
  output logic             ra_hit,
  output logic             rc_hit,
  output logic             ovf_hit,
  output logic             wave
);
  logic [CNT_W-1:0] cnt_q;
  logic             clken_q, wave_q, adv, reload_now;

  assign adv        = tick & clken_q;
  assign ra_hit     = adv && (cnt_q == ra);
  assign rc_hit     = adv && (cnt_q == rc);
  assign reload_now = auto_rld && rc_hit;
  assign ovf_hit    = adv && (&cnt_q) && !reload_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cmd_trig) cnt_q <= '0;
    else if (adv)      cnt_q <= CNT_W'(next_count(16'(cnt_q), reload_now));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  clken_q <= 1'b0;
    else if (cmd_dis)            clken_q <= 1'b0;
    else if (cmd_en)             clken_q <= 1'b1;
    else if (stop_rc && rc_hit)  clken_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wave_q <= 1'b0;
    else if (rc_hit) wave_q <= 1'b0;
    else if (ra_hit) wave_q <= 1'b1;
  end

  assign cnt   = cnt_q;
  assign clken = clken_q;
  assign wave  = wave_q;

  // R1: wrap lands on zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !cmd_trig) |=> (cnt_q == '0)) else $error("wrap not to zero");
  // R2: auto-reload returns to zero on RC
  assert_auto_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && auto_rld && !cmd_trig) |=> (cnt_q == '0)) else $error("no reload");
  // R3: one-shot stops the clock
  assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && stop_rc && !cmd_en) |=> !clken_q) else $error("one-shot kept running");
  // R4: trigger clears the count
  assert_trig_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_trig |=> (cnt_q == '0)) else $error("trigger did not restart");
  // R5: disable wins and holds the count
  assert_dis_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !clken_q) else $error("disable lost");
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_q && !cmd_trig) |=> $stable(cnt_q)) else $error("count moved while off");
  // R6: waveform set and clear
  assert_wave_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_hit && !rc_hit) |=> wave_q) else $error("output not set on RA");
  assert_wave_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rc_hit |=> !wave_q) else $error("output not cleared on RC");

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ev,
  input  logic       rd_clr,
  input  logic       ien_wr,
  input  logic       idis_wr,
  input  logic [7:0] wmask,
  input  logic       clken,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);
  logic [2:0] flags_q;
  logic [7:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (rd_clr ? 3'b000 : flags_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (ien_wr)  mask_q <= mask_q | wmask;
    else if (idis_wr) mask_q <= mask_q & ~wmask;
  end

  assign status = {clken, 4'b0000, flags_q};
  assign mask   = mask_q;
  assign irq    = |(flags_q & mask_q[2:0]);

  // R7: clearing with all ones empties the mask
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idis_wr && !ien_wr && wmask == 8'hFF) |=> (mask_q == 8'h00))
    else $error("mask not cleared");
  // R8: an enabled RC event raises the line
  assert_irq_rc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[ST_RC] && mask_q[ST_RC] && !idis_wr) |=> irq) else $error("irq missing");
  // R9: read clears flags when nothing new arrives
  assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == 3'b000) |=> (flags_q == 3'b000)) else $error("flags not cleared");

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic             tmr_out
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  ra_q, rc_q, cnt;
  logic cmd_wr, cmd_en, cmd_dis, cmd_trig, tick, clken;
  logic ra_hit, rc_hit, ovf_hit;
  logic [7:0] status, mask;

  assign cmd_wr   = wr_en && (addr == A_CMD);
  assign cmd_en   = cmd_wr && wdata[0];
  assign cmd_dis  = cmd_wr && wdata[1];
  assign cmd_trig = cmd_wr && wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ra_q   <= '0;
      rc_q   <= '0;
    end else if (wr_en) begin
      if (addr == A_MODE) mode_q <= wdata[MODE_W-1:0];
      if (addr == A_RA)   ra_q   <= wdata;
      if (addr == A_RC)   rc_q   <= wdata;
    end
  end

  tmr_clksel #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_src (
    .clk(clk), .rst_n(rst_n), .restart(cmd_trig), .sel(mode_q[2:0]),
    .slow_in(slow_clk), .ext_in(ext_clk), .tick(tick));

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .auto_rld(mode_q[MODE_AUTO]), .stop_rc(mode_q[MODE_STOP]),
    .ra(ra_q), .rc(rc_q),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig),
    .cnt(cnt), .clken(clken), .ra_hit(ra_hit), .rc_hit(rc_hit),
    .ovf_hit(ovf_hit), .wave(tmr_out));

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev({rc_hit, ra_hit, ovf_hit}),
    .rd_clr(rd_en && (addr == A_STAT)),
    .ien_wr(wr_en && (addr == A_IEN)), .idis_wr(wr_en && (addr == A_IDIS)),
    .wmask(wdata[7:0]), .clken(clken),
    .status(status), .mask(mask), .irq(irq));

  always_comb begin
    case (reg_addr_e'(addr))
      A_MODE:  rdata = CNT_W'(mode_q);
      A_CMD:   rdata = cnt;
      A_RA:    rdata = ra_q;
      A_RC:    rdata = rc_q;
      A_MASK:  rdata = CNT_W'(mask);
      A_STAT:  rdata = CNT_W'(status);
      default: rdata = '0;
    endcase
  end

  // R12: count register reads back zero after a trigger
  assert_cmd_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_trig |=> (cnt == '0)) else $error("count read path stale");

endmodule

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_clk = 1'b0, ext_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'd0, rdata;
  logic irq, tmr_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_chan u0 (.clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .ext_clk(ext_clk),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .tmr_out(tmr_out));

  // {source code, cycles after trigger, expected count}
  localparam int VEC [8][3] = '{
    '{0, 20, 10}, '{1, 40, 5}, '{2, 100, 3}, '{3, 300, 2},
    '{0, 1, 0},   '{1, 7, 0},  '{2, 64, 2},  '{3, 128, 1}};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic rd_stat(output int d);
    addr = 3'd7; rd_en = 1'b1; #1; d = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit on_ext, input int n);
    for (int i = 0; i < n; i++) begin
      if (on_ext) ext_clk = 1'b1; else slow_clk = 1'b1;
      waitn(3);
      if (on_ext) ext_clk = 1'b0; else slow_clk = 1'b0;
      waitn(3);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, h;
    waitn(3); rst_n = 1'b1; waitn(1);
    // R12 reset state
    peek(3'd1, v); check("R12 reset count", v, 0);
    peek(3'd6, v); check("R12 reset mask", v, 0);
    peek(3'd7, v); check("R12 reset status", v, 0);
    check("R8 reset irq", int'(irq), 0);
    check("R6 reset out", int'(tmr_out), 0);

    // R10 prescale table
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 16'(VEC[i][0]));
      wr(3'd1, 16'h5);
      waitn(VEC[i][1]);
      peek(3'd1, v);
      check("R10 prescaled count", v, VEC[i][2]);
      check("R10 restated", v, VEC[i][1] >> (1 + 2 * VEC[i][0]));
    end

    // R2 auto-reload, RC=3
    wr(3'd3, 16'd3); wr(3'd0, 16'h8); wr(3'd1, 16'h5);
    waitn(7); peek(3'd1, v); check("R2 top of cycle", v, 3);
    waitn(2); peek(3'd1, v); check("R2 back to zero", v, 0);
    // R4 trigger alone
    waitn(3); wr(3'd1, 16'h4);
    peek(3'd1, v); check("R4 trigger restart", v, 0);
    waitn(4); peek(3'd1, v); check("R4 counts after trigger", v, 2);

    // R5 disable, priority, re-enable
    wr(3'd0, 16'h0); wr(3'd1, 16'h5); waitn(10);
    wr(3'd1, 16'h2); peek(3'd1, h);
    waitn(10); peek(3'd1, v); check("R5 hold after disable", v, h);
    wr(3'd1, 16'h3); waitn(6); peek(3'd1, v); check("R5 disable wins", v, h);
    rd_stat(v); check("R5 clock-on bit clear", (v >> 7) & 1, 0);
    wr(3'd1, 16'h1); waitn(8); peek(3'd1, v); check("R5 resumes without reset", v, h + 4);

    // R6 waveform RA=2 RC=6
    wr(3'd2, 16'd2); wr(3'd3, 16'd6); wr(3'd0, 16'h0); wr(3'd1, 16'h5);
    waitn(6);  check("R6 high after RA", int'(tmr_out), 1);
    waitn(7);  check("R6 still high", int'(tmr_out), 1);
    waitn(1);  check("R6 low after RC", int'(tmr_out), 0);
    waitn(7);  check("R6 stays low past RC", int'(tmr_out), 0);

    // R7 mask edit
    wr(3'd1, 16'h2);
    wr(3'd4, 16'h05); peek(3'd6, v); check("R7 mask set", v, 8'h05);
    wr(3'd4, 16'h80); peek(3'd6, v); check("R7 mask accumulate", v, 8'h85);
    wr(3'd5, 16'hFF); peek(3'd6, v); check("R7 mask clear all", v, 0);

    // R3 one-shot, R8 irq, R9 clear-on-read
    rd_stat(v);
    wr(3'd2, 16'd0); wr(3'd3, 16'd2); wr(3'd4, 16'h04);
    wr(3'd0, 16'h18); wr(3'd1, 16'h5);
    waitn(20);
    peek(3'd1, v); check("R3 one-shot count", v, 0);
    check("R8 irq on RC", int'(irq), 1);
    rd_stat(v); check("R3 status after stop", v, 8'h06);
    check("R9 irq drops after read", int'(irq), 0);
    rd_stat(v); check("R9 flags cleared", v, 0);

    // R11 external sources
    wr(3'd0, 16'h4); wr(3'd1, 16'h5);
    pulse(1'b1, 3); pulse(1'b0, 5); waitn(6);
    peek(3'd1, v); check("R11 slow edges only", v, 5);
    wr(3'd0, 16'h5); wr(3'd1, 16'h5);
    pulse(1'b0, 2); pulse(1'b1, 3); waitn(6);
    peek(3'd1, v); check("R11 chained edges only", v, 3);
    wr(3'd0, 16'h6); wr(3'd1, 16'h5);
    pulse(1'b0, 2); pulse(1'b1, 2); waitn(6);
    peek(3'd1, v); check("R11 unused code", v, 0);

    // R1 free-run wrap past RC
    wr(3'd1, 16'h2); rd_stat(v);
    wr(3'd3, 16'd5); wr(3'd0, 16'h0); wr(3'd1, 16'h5);
    waitn(131070); peek(3'd1, v); check("R1 reaches top", v, 16'hFFFF);
    waitn(2); peek(3'd1, v); check("R1 wraps to zero", v, 0);
    rd_stat(v); check("R1 overflow flag", v, 8'h87);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule